// File: doc/BRIEF.md
# Frame-to-Frame Correlated Double Sampling Subtractor

This block sits directly behind the converter of one sensor sector. It receives a raster stream of 10-bit raw pixel samples, at most one per clock, and for every pixel it subtracts the sample that the same pixel delivered one frame earlier. The result is an 8-bit correlated-double-sampled value that is clamped to the 0..255 range. The earlier sample comes from an on-chip circular buffer that holds exactly one frame. Each accepted pixel costs one read, one subtraction and one write-back of the new raw sample to the same location. The buffer therefore always holds the most recent frame, and no pedestal table is loaded from outside.

Each buffer location also holds a hot-pixel flag. A pixel whose stored flag is set produces a zero result, so noisy pixels do not reach the cluster logic further down the chain. The flag for a pixel is written through a side input at the moment that pixel streams in, and it takes effect from that pixel's next visit. The frame size is set by two parameters, columns and rows. A full sector is 320 by 640, which is 204,800 locations. The default here is 32 by 64 so that the array elaborates at a small size. The first frame after reset is marked invalid because the buffer holds no earlier samples yet.

Top module: `cds_subtractor`

## Requirements
- R1: After reset, out_valid and out_frame_ok are 0, and the first accepted pixel is assigned address 0.
- R2: Each cycle with in_valid=1 gives exactly one output with out_valid=1 two clock edges later. A cycle with in_valid=0 gives out_valid=0 two edges later and does not advance the address.
- R3: Accepted pixels get consecutive raster addresses 0, 1, ..., COLS*ROWS-1, and the address then wraps to 0. out_addr carries the address of the pixel being output.
- R4: For every pixel of the first frame after reset, out_frame_ok=0 and out_value=0. From the first wrap onward, out_frame_ok=1 and stays 1 until the next reset.
- R5: For a valid, unmasked pixel outside the first frame, out_value equals the current sample minus the sample stored for that address in the previous frame, when that difference lies in 0..255.
- R6: A negative difference gives out_value=0.
- R7: A difference above 255 gives out_value=255.
- R8: When mask_we=1 with mask_val=1 on an accepted pixel, that pixel's stored hot flag is set. On the pixel's later visits, out_value=0 while out_frame_ok stays 1. When mask_we=0, the stored flag is kept, and it starts at 0 in the first frame.
- R9: When mask_we=1 with mask_val=0 on an accepted pixel, the flag is cleared, and on the next visit the pixel again shows the difference of R5..R7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | A raw sample is present this cycle |
| in_sample | input | 10 | Raw digitized pixel sample |
| mask_we | input | 1 | Write the hot flag of the current pixel |
| mask_val | input | 1 | Hot flag value written when mask_we=1 |
| out_valid | output | 1 | Result present |
| out_value | output | 8 | Clamped difference, or 0 for masked or first-frame pixels |
| out_addr | output | ceil(log2(COLS*ROWS)) | Raster address of the output pixel |
| out_frame_ok | output | 1 | 1 when an earlier frame exists for the subtraction |

## Verification
A wrong address counter shows up on the very next output as an out_addr mismatch. Because the buffer reads back only after a full frame, it also corrupts every difference one frame later. A faulty write-back or a wrong read location stays hidden for a whole frame and then spoils the differences of every affected pixel. Errors in the hot flag show up only on the pixel's next visit, as a zero where a difference was due or the reverse. The bench therefore runs many small frames with bubbles, so that each fault reaches the ports within one frame of the cycle that caused it.

// File: rtl/cds_pkg.sv
package cds_pkg;
    localparam int RAW_W = 10;
    localparam int OUT_W = 8;

    typedef struct packed {
        logic             hot;
        logic [RAW_W-1:0] raw;
    } cds_entry_t;

    // current minus previous, clamped into the output range
    function automatic logic [OUT_W-1:0] clamp_diff(input logic [RAW_W-1:0] cur,
                                                     input logic [RAW_W-1:0] prev);
        logic signed [RAW_W+1:0] d;
        d = $signed({2'b00, cur}) - $signed({2'b00, prev});
        if (d < 0)
            return '0;
        else if (d > $signed((RAW_W+2)'((1 << OUT_W) - 1)))
            return '1;
        else
            return d[OUT_W-1:0];
    endfunction
endpackage

// File: rtl/cds_addr_gen.sv
module cds_addr_gen #(
    parameter int FRAME_PIX = 2048,
    localparam int ADDR_W = $clog2(FRAME_PIX)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              adv,
    output logic [ADDR_W-1:0] addr,
    output logic              first_frame
);
    localparam logic [ADDR_W-1:0] LAST = ADDR_W'(FRAME_PIX - 1);

    always_ff @(posedge clk) begin
        if (rst) begin
            addr        <= '0;
            first_frame <= 1'b1;
        end else if (adv) begin
            if (addr == LAST) begin
                addr        <= '0;
                first_frame <= 1'b0;
            end else begin
                addr <= addr + 1'b1;
            end
        end
    end
endmodule

// File: rtl/cds_frame_mem.sv
module cds_frame_mem
    import cds_pkg::*;
#(
    parameter int FRAME_PIX = 2048,
    localparam int ADDR_W = $clog2(FRAME_PIX)
) (
    input  logic              clk,
    input  logic [ADDR_W-1:0] rd_addr,
    output cds_entry_t        rd_data,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  cds_entry_t        wr_data
);
    cds_entry_t mem [FRAME_PIX];

    always_ff @(posedge clk) begin
        rd_data <= mem[rd_addr];
        if (wr_en)
            mem[wr_addr] <= wr_data;
    end
endmodule

// File: rtl/cds_diff_unit.sv
module cds_diff_unit
    import cds_pkg::*;
(
    input  logic [RAW_W-1:0] cur,
    input  cds_entry_t       stored,
    input  logic             first,
    input  logic             mask_we,
    input  logic             mask_val,
    output logic [OUT_W-1:0] value,
    output cds_entry_t       wb
);
    logic hot_old;

    always_comb begin
        hot_old = first ? 1'b0 : stored.hot;
        if (first || hot_old)
            value = '0;
        else
            value = clamp_diff(cur, stored.raw);
        wb.raw = cur;
        wb.hot = mask_we ? mask_val : hot_old;
    end
endmodule

// File: rtl/cds_subtractor.sv
module cds_subtractor
    import cds_pkg::*;
#(
    parameter int SECT_COLS = 32,
    parameter int SECT_ROWS = 64,
    localparam int FRAME_PIX = SECT_COLS * SECT_ROWS,
    localparam int ADDR_W = $clog2(FRAME_PIX)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [RAW_W-1:0]  in_sample,
    input  logic              mask_we,
    input  logic              mask_val,
    output logic              out_valid,
    output logic [OUT_W-1:0]  out_value,
    output logic [ADDR_W-1:0] out_addr,
    output logic              out_frame_ok
);
    typedef struct packed {
        logic              valid;
        logic              first;
        logic              mwe;
        logic              mval;
        logic [ADDR_W-1:0] addr;
        logic [RAW_W-1:0]  sample;
    } stage_t;

    logic [ADDR_W-1:0] cur_addr;
    logic              cur_first;
    stage_t            s1;
    cds_entry_t        rd_entry;
    cds_entry_t        wb_entry;
    logic [OUT_W-1:0]  diff_val;

    cds_addr_gen #(.FRAME_PIX(FRAME_PIX)) u_addr (
        .clk(clk), .rst(rst), .adv(in_valid),
        .addr(cur_addr), .first_frame(cur_first)
    );

    // Read happens as the pixel enters; write-back one cycle later,
    // always to a different location than the concurrent read.
    cds_frame_mem #(.FRAME_PIX(FRAME_PIX)) u_mem (
        .clk(clk), .rd_addr(cur_addr), .rd_data(rd_entry),
        .wr_en(s1.valid), .wr_addr(s1.addr), .wr_data(wb_entry)
    );

    cds_diff_unit u_diff (
        .cur(s1.sample), .stored(rd_entry), .first(s1.first),
        .mask_we(s1.mwe), .mask_val(s1.mval),
        .value(diff_val), .wb(wb_entry)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            s1 <= '0;
        end else begin
            s1.valid  <= in_valid;
            s1.first  <= cur_first;
            s1.mwe    <= mask_we & in_valid;
            s1.mval   <= mask_val;
            s1.addr   <= cur_addr;
            s1.sample <= in_sample;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid    <= 1'b0;
            out_value    <= '0;
            out_addr     <= '0;
            out_frame_ok <= 1'b0;
        end else begin
            out_valid <= s1.valid;
            if (s1.valid) begin
                out_value    <= diff_val;
                out_addr     <= s1.addr;
                out_frame_ok <= ~s1.first;
            end
        end
    end
endmodule

// File: rtl/cds_checks.sv
module cds_checks #(
    parameter int FRAME_PIX = 2048,
    localparam int ADDR_W = $clog2(FRAME_PIX)
) (
    input logic              clk,
    input logic              rst,
    input logic              in_valid,
    input logic              out_valid,
    input logic [7:0]        out_value,
    input logic [ADDR_W-1:0] out_addr,
    input logic              out_frame_ok
);
    localparam logic [ADDR_W-1:0] LAST = ADDR_W'(FRAME_PIX - 1);

    logic [1:0]        cyc;
    logic [ADDR_W-1:0] exp_addr;

    always_ff @(posedge clk) begin
        if (rst) begin
            cyc      <= '0;
            exp_addr <= '0;
        end else begin
            if (cyc != 2'd3) cyc <= cyc + 1'b1;
            if (out_valid) exp_addr <= (out_addr == LAST) ? '0 : out_addr + 1'b1;
        end
    end

    p_latency_r2: assert property (@(posedge clk) disable iff (rst)
        (cyc >= 2'd2) |-> (out_valid == $past(in_valid, 2)));

    p_addr_seq_r3: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (out_addr == exp_addr));

    p_first_zero_r4: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_frame_ok) |-> (out_value == 8'd0));

    p_ok_sticky_r4: assert property (@(posedge clk) disable iff (rst)
        out_frame_ok |=> out_frame_ok);
endmodule

bind cds_subtractor cds_checks #(.FRAME_PIX(FRAME_PIX)) u_checks (
    .clk(clk), .rst(rst), .in_valid(in_valid), .out_valid(out_valid),
    .out_value(out_value), .out_addr(out_addr), .out_frame_ok(out_frame_ok)
);

// File: tb/sim_cds_subtractor.sv
`timescale 1ns/1ps
module sim_cds_subtractor;
    localparam int COLS = 4;
    localparam int ROWS = 4;
    localparam int NPIX = COLS * ROWS;
    localparam int AW   = $clog2(NPIX);

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          in_valid = 1'b0;
    logic [9:0]    in_sample = '0;
    logic          mask_we = 1'b0;
    logic          mask_val = 1'b0;
    logic          out_valid;
    logic [7:0]    out_value;
    logic [AW-1:0] out_addr;
    logic          out_frame_ok;

    always #2.5 clk = ~clk;

    cds_subtractor #(.SECT_COLS(COLS), .SECT_ROWS(ROWS)) u0 (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_sample(in_sample),
        .mask_we(mask_we), .mask_val(mask_val), .out_valid(out_valid),
        .out_value(out_value), .out_addr(out_addr), .out_frame_ok(out_frame_ok)
    );

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;

    // reference model
    int  m_raw [NPIX];
    bit  m_hot [NPIX];
    bit  m_clr [NPIX];
    int  m_addr = 0;
    bit  m_first = 1'b1;

    // expectation pipe, two entries deep
    bit    p_v  [2];
    int    p_val[2];
    int    p_adr[2];
    bit    p_ok [2];
    string p_tag[2];

    task automatic check(input bit cond, input string tag, input string what,
                         input int act, input int exp);
        tests++;
        if (!cond) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    task automatic step(input bit v, input int s, input bit we, input bit mv);
        int d;
        @(negedge clk);
        if (p_v[1]) begin
            check(out_valid == 1'b1, "R2", "out_valid", int'(out_valid), 1);
            check(int'(out_addr) == p_adr[1], "R3", "out_addr", int'(out_addr), p_adr[1]);
            check(out_frame_ok == p_ok[1], p_tag[1], "out_frame_ok", int'(out_frame_ok), int'(p_ok[1]));
            check(int'(out_value) == p_val[1], p_tag[1], "out_value", int'(out_value), p_val[1]);
        end else begin
            check(out_valid == 1'b0, "R2", "out_valid bubble", int'(out_valid), 0);
        end
        p_v[1] = p_v[0]; p_val[1] = p_val[0]; p_adr[1] = p_adr[0];
        p_ok[1] = p_ok[0]; p_tag[1] = p_tag[0];
        p_v[0] = v;
        in_valid  = v;
        in_sample = 10'(s);
        mask_we   = we;
        mask_val  = mv;
        if (v) begin
            bit hot_old;
            hot_old  = m_first ? 1'b0 : m_hot[m_addr];
            d        = s - m_raw[m_addr];
            p_adr[0] = m_addr;
            p_ok[0]  = !m_first;
            if (m_first) begin
                p_val[0] = 0; p_tag[0] = "R4";
            end else if (hot_old) begin
                p_val[0] = 0; p_tag[0] = "R8";
            end else begin
                p_val[0] = (d < 0) ? 0 : (d > 255) ? 255 : d;
                if (m_clr[m_addr])  p_tag[0] = "R9";
                else if (d < 0)     p_tag[0] = "R6";
                else if (d > 255)   p_tag[0] = "R7";
                else                p_tag[0] = "R5";
            end
            m_clr[m_addr] = we && !mv && hot_old;
            m_hot[m_addr] = we ? mv : hot_old;
            m_raw[m_addr] = s;
            if (m_addr == NPIX - 1) begin
                m_addr = 0; m_first = 1'b0;
            end else begin
                m_addr++;
            end
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 2; i++) begin
            p_v[i] = 0; p_val[i] = 0; p_adr[i] = 0; p_ok[i] = 0; p_tag[i] = "R2";
        end
        for (int i = 0; i < NPIX; i++) begin
            m_raw[i] = 0; m_hot[i] = 0; m_clr[i] = 0;
        end
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R1: quiet outputs right after reset
        check(out_valid == 1'b0, "R1", "out_valid after reset", int'(out_valid), 0);
        check(out_frame_ok == 1'b0, "R1", "out_frame_ok after reset", int'(out_frame_ok), 0);
        check(out_addr == '0, "R1", "out_addr after reset", int'(out_addr), 0);

        for (int f = 0; f < 30; f++) begin
            for (int p = 0; p < NPIX; p++) begin
                int s;
                bit we, mv;
                if (f == 4)      s = 0;
                else if (f == 5) s = 1023;
                else if (f == 6) s = 0;
                else             s = (f * 389 + p * 157 + f * p * 29) % 1024;
                we = (p % 5 == 0) && (f % 3 != 0);
                mv = (f % 3 == 1);
                if ((f * p) % 7 == 3) step(1'b0, 0, 1'b0, 1'b0);
                step(1'b1, s, we, mv);
            end
        end
        step(1'b0, 0, 1'b0, 1'b0);
        step(1'b0, 0, 1'b0, 1'b0);
        step(1'b0, 0, 1'b0, 1'b0);
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule